// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Address Stall

This block is a single-port synchronous memory. One port carries the address, write data, a write enable, per-byte write enables, a read enable, a clock enable and an address-stall control. All of these are sampled on the rising edge of the input clock. There is no path from any input to the array that bypasses that edge. Each enabled cycle performs exactly one operation: a write when the write enable is high, a read when only the read enable is high, and nothing otherwise.

The address is held in a register. When the stall control is high, that register keeps its current value and the operation uses the held address instead of the one on the port. This lets a read or write repeat on the same location while the upstream address bus moves on.

A parameter chooses what the read data shows during a write cycle: the newly merged word, the word that was in the location before the write, or an unspecified result. In this implementation, the unspecified result leaves the read data unchanged. The read word can go through an output register. That register has its own clock and an asynchronous clear.

Top module: `spram_stall`

## Requirements
- R1: During a write, byte enable bit i selects whether bits 8i+7..8i of the addressed word take the write data (bit i = 1) or keep their stored value (bit i = 0).
- R2: A cycle with clock enable 1, write enable 0 and read enable 1 loads the addressed word into the internal read word at that input-clock edge. With the output register on, q shows it after the next output-clock edge.
- R3: When address stall is 1 at an enabled edge, the address register keeps its value and that cycle's read or write uses the held address. When stall is 0, the port address is captured and used.
- R4: When clock enable is 0 at an input-clock edge, nothing is written, nothing is read, the address register holds and the read word holds.
- R5: A cycle with both write enable and read enable high is a single write. It performs no separate read.
- R6: With the mode set to new data (value 0), the read word after a write cycle equals the merged word written.
- R7: With the mode set to old data (value 1), the read word after a write cycle equals the word stored at that address before the write.
- R8: With the mode set to don't care (value 2), a write cycle leaves the read word unchanged.
- R9: While the output clear is high, q is zero at once, independent of the output clock. After the clear is released, the next output-clock edge reloads q from the read word.
- R10: An active-low reset sets the read word and the address register to zero and leaves the array contents untouched.
- R11: An enabled cycle with both write enable and read enable low changes neither the array nor the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; samples every port input |
| rst_n | input | 1 | Asynchronous active-low reset of the address register and read word |
| ce | input | 1 | Clock enable for all input-side registers and the operation |
| addr_stall | input | 1 | 1 = keep the held address, ignore `addr` |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write enable; has priority over read |
| be | input | DATA_W/8 | Per-byte write enables |
| re | input | 1 | Read enable |
| clk_out | input | 1 | Output register clock |
| q_clr | input | 1 | Asynchronous clear of the output register, active high |
| q | output | DATA_W | Read data |

## Verification
An operation presented before input-clock edge k updates the array and the internal read word at edge k. With the output register on and both clocks tied together, q carries that result after edge k+1. The bench drives inputs on falling edges. After each operation it inserts one enabled idle cycle with stall held high, so that edge k+1 changes nothing upstream, and it samples q on the falling edge after k+1. The asynchronous clear is checked 1 ns after it rises, before any clock edge, and checked again after one edge while it is still held.

// File: rtl/spram_pkg.sv
package spram_pkg;

    typedef enum logic [1:0] {
        RDW_NEW_DATA  = 2'd0,
        RDW_OLD_DATA  = 2'd1,
        RDW_DONT_CARE = 2'd2
    } rdw_mode_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/spram_req_stage.sv
module spram_req_stage #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int BYTES  = DATA_W / spram_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              stall,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BYTES-1:0]  be_i,
    input  logic              we_i,
    input  logic              re_i,
    output logic              op_write,
    output logic              op_read,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_wdata,
    output logic [BYTES-1:0]  op_be,
    output logic [ADDR_W-1:0] addr_hold
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BYTES-1:0]  be;
        logic              we;
        logic              re;
    } req_t;

    req_t req_d, req_q;

    // next value of every captured input
    always_comb begin
        req_d = req_q;
        if (ce) begin
            req_d.addr  = stall ? req_q.addr : addr_i;
            req_d.wdata = wdata_i;
            req_d.be    = be_i;
            req_d.we    = we_i;
            req_d.re    = re_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    // the array acts on the word captured at this same edge
    assign op_write  = ce & we_i;
    assign op_read   = ce & ~we_i & re_i;
    assign op_addr   = req_d.addr;
    assign op_wdata  = req_d.wdata;
    assign op_be     = req_d.be;
    assign addr_hold = req_q.addr;

endmodule

// File: rtl/spram_core.sv
module spram_core #(
    parameter int                    ADDR_W   = 4,
    parameter int                    DATA_W   = 16,
    parameter spram_pkg::rdw_mode_e  RDW_MODE = spram_pkg::RDW_NEW_DATA,
    parameter int                    BYTES    = DATA_W / spram_pkg::LANE_W,
    parameter int                    DEPTH    = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_write,
    input  logic              op_read,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic [BYTES-1:0]  op_be,
    output logic [DATA_W-1:0] rd_word
);

    localparam int LW = spram_pkg::LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } core_t;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] stored_word;
    logic [DATA_W-1:0] merged_word;
    core_t             core_d, core_q;

    assign stored_word = mem[op_addr];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign merged_word[g*LW +: LW] = op_be[g] ? op_wdata[g*LW +: LW]
                                                  : stored_word[g*LW +: LW];
    end

    always_comb begin
        core_d = core_q;
        if (op_write) begin
            case (RDW_MODE)
                spram_pkg::RDW_NEW_DATA: core_d.rd = merged_word;
                spram_pkg::RDW_OLD_DATA: core_d.rd = stored_word;
                default:                 core_d.rd = core_q.rd;
            endcase
        end else if (op_read) begin
            core_d.rd = stored_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    // array has no reset; contents survive rst_n
    always_ff @(posedge clk) begin
        if (op_write) begin
            mem[op_addr] <= merged_word;
        end
    end

    assign rd_word = core_q.rd;

endmodule

// File: rtl/spram_out_reg.sv
module spram_out_reg #(
    parameter int DATA_W  = 16,
    parameter bit USE_REG = 1'b1
) (
    input  logic              clk_out,
    input  logic              clr,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    if (USE_REG) begin : g_reg
        logic [DATA_W-1:0] q_d, q_q;

        always_comb begin
            q_d = d;
        end

        always_ff @(posedge clk_out or posedge clr) begin
            if (clr) begin
                q_q <= '0;
            end else begin
                q_q <= q_d;
            end
        end

        assign q = q_q;
    end else begin : g_flow
        assign q = d;
    end

endmodule

// File: rtl/spram_stall.sv
module spram_stall #(
    parameter int                    ADDR_W   = 4,
    parameter int                    DATA_W   = 16,
    parameter spram_pkg::rdw_mode_e  RDW_MODE = spram_pkg::RDW_NEW_DATA,
    parameter bit                    OUT_REG  = 1'b1
) (
    input  logic                                clk_in,
    input  logic                                rst_n,
    input  logic                                ce,
    input  logic                                addr_stall,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic                                we,
    input  logic [DATA_W/spram_pkg::LANE_W-1:0] be,
    input  logic                                re,
    input  logic                                clk_out,
    input  logic                                q_clr,
    output logic [DATA_W-1:0]                   q
);

    localparam int BYTES = DATA_W / spram_pkg::LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic              op_write;
    logic              op_read;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;
    logic [BYTES-1:0]  op_be;
    logic [ADDR_W-1:0] addr_hold;
    logic [DATA_W-1:0] rd_word;

    spram_req_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BYTES  (BYTES)
    ) u_req (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .ce        (ce),
        .stall     (addr_stall),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .be_i      (be),
        .we_i      (we),
        .re_i      (re),
        .op_write  (op_write),
        .op_read   (op_read),
        .op_addr   (op_addr),
        .op_wdata  (op_wdata),
        .op_be     (op_be),
        .addr_hold (addr_hold)
    );

    spram_core #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RDW_MODE (RDW_MODE),
        .BYTES    (BYTES),
        .DEPTH    (DEPTH)
    ) u_core (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .op_write (op_write),
        .op_read  (op_read),
        .op_addr  (op_addr),
        .op_wdata (op_wdata),
        .op_be    (op_be),
        .rd_word  (rd_word)
    );

    spram_out_reg #(
        .DATA_W  (DATA_W),
        .USE_REG (OUT_REG)
    ) u_out (
        .clk_out (clk_out),
        .clr     (q_clr),
        .d       (rd_word),
        .q       (q)
    );

endmodule

// File: rtl/spram_stall_chk.sv
module spram_stall_chk #(
    parameter int                    ADDR_W   = 4,
    parameter int                    DATA_W   = 16,
    parameter spram_pkg::rdw_mode_e  RDW_MODE = spram_pkg::RDW_NEW_DATA,
    parameter bit                    OUT_REG  = 1'b1,
    parameter int                    BYTES    = DATA_W / spram_pkg::LANE_W
) (
    input logic              clk_in,
    input logic              rst_n,
    input logic              ce,
    input logic              addr_stall,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              we,
    input logic [BYTES-1:0]  be,
    input logic              re,
    input logic              q_clr,
    input logic [DATA_W-1:0] q,
    input logic [ADDR_W-1:0] addr_hold,
    input logic [DATA_W-1:0] rd_word
);

    localparam bit IS_NEW = (RDW_MODE == spram_pkg::RDW_NEW_DATA);
    localparam bit IS_DC  = (RDW_MODE == spram_pkg::RDW_DONT_CARE);

    p_stall_hold_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        ce && addr_stall |=> addr_hold == $past(addr_hold));

    p_addr_capture_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        ce && !addr_stall |=> addr_hold == $past(addr));

    p_ce_low_hold_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
        !ce |=> $stable(rd_word) && $stable(addr_hold));

    p_full_write_new_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        IS_NEW && ce && we && (&be) |=> rd_word == $past(wdata));

    p_write_keeps_rd_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
        IS_DC && ce && we |=> $stable(rd_word));

    p_clear_zero_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
        OUT_REG && q_clr |-> q == '0);

    p_idle_hold_r11: assert property (@(posedge clk_in) disable iff (!rst_n)
        ce && !we && !re |=> $stable(rd_word));

endmodule

bind spram_stall spram_stall_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RDW_MODE (RDW_MODE),
    .OUT_REG  (OUT_REG)
) u_chk (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .ce         (ce),
    .addr_stall (addr_stall),
    .addr       (addr),
    .wdata      (wdata),
    .we         (we),
    .be         (be),
    .re         (re),
    .q_clr      (q_clr),
    .q          (q),
    .addr_hold  (addr_hold),
    .rd_word    (rd_word)
);

// File: tb/spram_stall_tb.sv
module spram_stall_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int BW = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce;
    logic          stall;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          we;
    logic [BW-1:0] be;
    logic          re;
    logic          q_clr;
    logic [DW-1:0] q_new, q_old, q_dc;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] hold;
    logic [DW-1:0] e_new, e_old, e_dc;

    always #(CLK_PERIOD/2) clk = ~clk;

    spram_stall #(.ADDR_W(AW), .DATA_W(DW), .RDW_MODE(spram_pkg::RDW_NEW_DATA), .OUT_REG(1'b1)) u_dut (
        .clk_in(clk), .rst_n(rst_n), .ce(ce), .addr_stall(stall), .addr(addr), .wdata(wdata),
        .we(we), .be(be), .re(re), .clk_out(clk), .q_clr(q_clr), .q(q_new));

    spram_stall #(.ADDR_W(AW), .DATA_W(DW), .RDW_MODE(spram_pkg::RDW_OLD_DATA), .OUT_REG(1'b1)) u_dut_old (
        .clk_in(clk), .rst_n(rst_n), .ce(ce), .addr_stall(stall), .addr(addr), .wdata(wdata),
        .we(we), .be(be), .re(re), .clk_out(clk), .q_clr(q_clr), .q(q_old));

    spram_stall #(.ADDR_W(AW), .DATA_W(DW), .RDW_MODE(spram_pkg::RDW_DONT_CARE), .OUT_REG(1'b1)) u_dut_dc (
        .clk_in(clk), .rst_n(rst_n), .ce(ce), .addr_stall(stall), .addr(addr), .wdata(wdata),
        .we(we), .be(be), .re(re), .clk_out(clk), .q_clr(q_clr), .q(q_dc));

    task automatic chk(input string tag, input string who, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, who, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "new", q_new, e_new);
        chk(tag, "old", q_old, e_old);
        chk(tag, "dc",  q_dc,  e_dc);
    endtask

    // one operation, then one enabled idle cycle with stall held, then sample
    task automatic op(input logic c, input logic st, input logic w, input logic r,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] b);
        logic [AW-1:0] ea;
        logic [DW-1:0] prev, mer;
        @(negedge clk);
        ce = c; stall = st; we = w; re = r; addr = a; wdata = d; be = b;
        if (c) begin
            if (!st) hold = a;
            ea = hold;
            if (w) begin
                prev = ref_mem[ea];
                for (int i = 0; i < BW; i++)
                    mer[i*8 +: 8] = b[i] ? d[i*8 +: 8] : prev[i*8 +: 8];
                ref_mem[ea] = mer;
                e_new = mer;
                e_old = prev;
            end else if (r) begin
                e_new = ref_mem[ea];
                e_old = ref_mem[ea];
                e_dc  = ref_mem[ea];
            end
        end
        @(negedge clk);
        ce = 1'b1; stall = 1'b1; we = 1'b0; re = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; q_clr = 1'b1; ce = 1'b0; stall = 1'b0; addr = '0;
        wdata = '0; we = 1'b0; be = '0; re = 1'b0;
        hold = '0; e_new = '0; e_old = '0; e_dc = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk_all("R10 reset");
        rst_n = 1'b1; q_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_all("R10 after release");

        // fill every word; R6 new-data result checked on each write
        for (int a = 0; a < DEPTH; a++) begin
            op(1, 0, 1, 0, a[AW-1:0], 16'h5A00 ^ (a * 16'h1111), 2'b11);
            chk("R6 fill", "new", q_new, e_new);
        end

        // R2: read sweep
        for (int a = 0; a < DEPTH; a++) begin
            op(1, 0, 0, 1, a[AW-1:0], 16'hFFFF, 2'b00);
            chk_all("R2 read");
        end

        // R1, R6, R7, R8: byte-enable sweep with read-back
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < (1 << BW); b++) begin
                op(1, 0, 1, 0, a[AW-1:0], 16'hC3A5 + (a * 16'h0301) + (b * 16'h1010), b[BW-1:0]);
                chk_all("R1/R6/R7/R8 write");
                op(1, 0, 0, 1, a[AW-1:0], 16'h0000, 2'b00);
                chk_all("R1 readback");
            end
        end

        // R5: we and re together is a single write
        op(1, 0, 1, 1, 4'd6, 16'hBEEF, 2'b11);
        chk_all("R5 we+re");
        op(1, 0, 0, 1, 4'd6, 16'h0, 2'b00);
        chk_all("R5 readback");

        // R3: stall keeps the held address for read and write
        op(1, 0, 0, 1, 4'd3, 16'h0, 2'b00);
        chk_all("R3 set hold");
        op(1, 1, 0, 1, 4'd9, 16'h0, 2'b00);
        chk_all("R3 stalled read");
        op(1, 1, 1, 0, 4'd12, 16'h7E57, 2'b11);
        chk_all("R3 stalled write");
        op(1, 0, 0, 1, 4'd12, 16'h0, 2'b00);
        chk_all("R3 other addr intact");
        op(1, 0, 0, 1, 4'd3, 16'h0, 2'b00);
        chk_all("R3 held addr written");

        // R4: clock enable low
        op(0, 0, 1, 0, 4'd5, 16'hDEAD, 2'b11);
        chk_all("R4 no write q");
        op(0, 0, 0, 1, 4'd8, 16'h0, 2'b00);
        chk_all("R4 no read");
        op(1, 1, 0, 1, 4'd1, 16'h0, 2'b00);
        chk_all("R4 hold kept");
        op(1, 0, 0, 1, 4'd5, 16'h0, 2'b00);
        chk_all("R4 word intact");

        // R11: enabled idle cycle
        op(1, 0, 0, 0, 4'd10, 16'h1234, 2'b11);
        chk_all("R11 idle");
        op(1, 0, 0, 1, 4'd10, 16'h0, 2'b00);
        chk_all("R11 word intact");

        // R9: asynchronous clear
        @(negedge clk);
        q_clr = 1'b1;
        #1;
        chk("R9 immediate", "new", q_new, '0);
        chk("R9 immediate", "old", q_old, '0);
        chk("R9 immediate", "dc",  q_dc,  '0);
        @(negedge clk);
        chk("R9 held", "new", q_new, '0);
        q_clr = 1'b0;
        @(negedge clk);
        chk_all("R9 reload");

        // R10: reset mid-run keeps array, zeroes address and read word
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        hold = '0; e_new = '0; e_old = '0; e_dc = '0;
        chk_all("R10 rerun");
        op(1, 1, 0, 1, 4'd7, 16'h0, 2'b00);
        chk_all("R10 addr zero");

        finish_run();
    end

endmodule